// File: doc/BRIEF.md
# Serial Telegram Packet Transmitter

This block sends short telegram packets over one serial line, one bit per serial clock cycle. A user pushes requests on an independent write clock. Each request carries a type byte, a 32-bit word and a format flag, and it crosses into the serial clock domain through a 16-entry asynchronous FIFO with Gray-coded pointers. The serial side turns each request into a packet. A packet holds a start byte and the type byte. A data packet then adds the 32-bit word. Both formats end with an 8-bit CRC. Whenever no packet is on the line, the fixed 16-bit idle word is sent, over and over. The block also drives a clock at one quarter of the serial clock rate.

The serial side is a five-state machine. `ST_IDLE` shifts out the idle word. At the last idle bit it moves to `ST_START` if the FIFO holds an entry, popping that entry in the same cycle; otherwise it stays in `ST_IDLE` and starts a new idle word. `ST_START` sends the start byte and then moves to `ST_TYPE`. `ST_TYPE` sends the type byte and then moves to `ST_DATA` for a data packet or to `ST_CRC` for an event packet. `ST_DATA` sends the word and then moves to `ST_CRC`. `ST_CRC` sends the CRC and then always returns to `ST_IDLE`. A full idle word therefore separates any two packets.

Top module: `telegram_tx`

## Requirements
- R1: When no packet is being sent, the line carries the idle word 0x5885, MSB first, repeated. The first 16 bits after reset are always one idle word.
- R2: Every packet begins with the start byte 0x2C, sent MSB first.
- R3: An event packet is exactly the start byte, the type byte and the CRC byte, 24 bits in all, with no data field.
- R4: A data packet is the start byte, the type byte, the 32-bit word (most significant byte first, MSB first) and the CRC byte, 56 bits in all.
- R5: The write flag picks the format: 1 gives a data packet and 0 gives an event packet.
- R6: The CRC byte is CRC-8 with polynomial x^8+x^2+x+1 (0x07) and initial value 0x00. It is taken over the type byte and then, for data packets only, the four data bytes, most significant first, MSB first. The start byte is not included.
- R7: A packet starts only at the end of a complete idle word. Exactly one full idle word follows every packet before anything else can be sent.
- R8: Writes accepted on the write clock are sent as packets in write order. Up to 16 writes can be held.
- R9: A write while the FIFO is full is dropped and sets `wr_overflow`. That flag stays at 1 until reset and is 0 after reset.
- R10: `ser_clk_div` runs at one quarter of the serial clock. After reset it is low for two serial cycles and then high for two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | User write clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_en | input | 1 | Write request, one entry per cycle |
| wr_is_data | input | 1 | 1 gives a data packet, 0 gives an event packet |
| wr_type | input | 8 | Type byte of the packet |
| wr_data | input | 32 | Data word, used by data packets only |
| wr_overflow | output | 1 | Sticky flag: a write was dropped because the FIFO was full |
| ser_clk | input | 1 | Serial bit clock |
| ser_rst_n | input | 1 | Active-low asynchronous reset, serial domain |
| ser_out | output | 1 | Serial line |
| ser_clk_div | output | 1 | Serial clock divided by four |

## Verification
If a state or bit counter goes wrong, the line leaves its 16-bit framing. The fault shows up as a corrupt idle word, a missing or extra data field, or a packet that starts in the middle of an idle word. It appears within one packet length of the fault, because every packet must be followed by exactly one idle word. A wrong latched entry or CRC shows up as a mismatched type, word or CRC byte in the very next packet. A FIFO pointer fault shows up as packets that are lost, repeated or out of order, or as a missing or spurious overflow flag after a burst of writes.

// File: rtl/tel_pkg.sv
package tel_pkg;
    localparam logic [7:0]  START_BYTE = 8'h2C;
    localparam logic [15:0] IDLE_WORD  = 16'h5885;
    localparam logic [7:0]  CRC_POLY   = 8'h07;

    typedef struct packed {
        logic        is_data;
        logic [7:0]  kind;
        logic [31:0] payload;
    } tel_entry_t;

    typedef enum logic [2:0] {ST_IDLE, ST_START, ST_TYPE, ST_DATA, ST_CRC} tx_state_e;

    // One byte through the CRC register, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
        logic [7:0] c;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            if (c[7] ^ b[i]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction
endpackage

// File: rtl/tel_async_fifo.sv
module tel_async_fifo #(
    parameter int W  = 41,
    parameter int AW = 4
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_din,
    output logic         overflow,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_dout,
    output logic         empty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, rq1, rq2, wbin_nx;
    logic [AW:0]  rbin, rgray, wq1, wq2, rbin_nx;
    logic         full;

    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;
    assign full    = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
    assign empty   = (rgray == wq2);
    assign rd_dout = mem[rbin[AW-1:0]];

    // write domain
    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            rq1      <= '0;
            rq2      <= '0;
            overflow <= 1'b0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
            if (wr_en && !full) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (wr_en && full) overflow <= 1'b1;
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_din;
    end

    // read domain
    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            wq1   <= '0;
            wq2   <= '0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
            if (rd_en && !empty) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && full) |=> $stable(wbin)); // R9
    AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        overflow |=> overflow); // R9
    AST_NO_POP_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_en |-> !empty); // R8
endmodule

// File: rtl/tel_framer.sv
module tel_framer
    import tel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  tel_entry_t fifo_head,
    output logic       fifo_pop,
    output logic       ser_out
);
    tx_state_e  state_q, state_d;
    logic [4:0] cnt_q, cnt_d;
    tel_entry_t cur_q;
    logic [7:0] crc_q, head_crc;
    logic       field_done;

    // CRC of the entry at the FIFO head, latched when it is popped
    always_comb begin
        head_crc = crc8_step(8'h00, fifo_head.kind);
        if (fifo_head.is_data) begin
            for (int k = 3; k >= 0; k--) head_crc = crc8_step(head_crc, fifo_head.payload[8*k +: 8]);
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: field_done = (cnt_q == 5'd15);
            ST_DATA: field_done = (cnt_q == 5'd31);
            default: field_done = (cnt_q == 5'd7);
        endcase
        if (field_done) begin
            cnt_d = '0;
            unique case (state_q)
                ST_IDLE:  state_d = fifo_empty ? ST_IDLE : ST_START;
                ST_START: state_d = ST_TYPE;
                ST_TYPE:  state_d = cur_q.is_data ? ST_DATA : ST_CRC;
                ST_DATA:  state_d = ST_CRC;
                ST_CRC:   state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cur_q   <= '0;
            crc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (fifo_pop) begin
                cur_q <= fifo_head;
                crc_q <= head_crc;
            end
        end
    end

    // outputs
    always_comb begin
        fifo_pop = (state_q == ST_IDLE) && (cnt_q == 5'd15) && !fifo_empty;
        unique case (state_q)
            ST_IDLE:  ser_out = IDLE_WORD[~cnt_q[3:0]];
            ST_START: ser_out = START_BYTE[~cnt_q[2:0]];
            ST_TYPE:  ser_out = cur_q.kind[~cnt_q[2:0]];
            ST_DATA:  ser_out = cur_q.payload[~cnt_q];
            ST_CRC:   ser_out = crc_q[~cnt_q[2:0]];
            default:  ser_out = 1'b0;
        endcase
    end

    AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && cnt_q == 5'd0) |-> ($past(state_q) == ST_IDLE && $past(cnt_q) == 5'd15)); // R7
    AST_DATA_ONLY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> cur_q.is_data); // R5
    AST_CRC_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CRC && cnt_q == 5'd7) |=> (state_q == ST_IDLE && cnt_q == 5'd0)); // R7
endmodule

// File: rtl/telegram_tx.sv
module telegram_tx
    import tel_pkg::*;
#(
    parameter int FIFO_AW  = 4,
    parameter int DIV_LOG2 = 2
) (
    input  logic        wr_clk,
    input  logic        wr_rst_n,
    input  logic        wr_en,
    input  logic        wr_is_data,
    input  logic [7:0]  wr_type,
    input  logic [31:0] wr_data,
    output logic        wr_overflow,
    input  logic        ser_clk,
    input  logic        ser_rst_n,
    output logic        ser_out,
    output logic        ser_clk_div
);
    localparam int ENTRY_W = $bits(tel_entry_t);

    tel_entry_t           wr_entry, rd_entry;
    logic [ENTRY_W-1:0]   rd_vec;
    logic                 fifo_empty, fifo_pop;
    logic [DIV_LOG2-1:0]  div_cnt;

    assign wr_entry = '{is_data: wr_is_data, kind: wr_type, payload: wr_data};
    assign rd_entry = tel_entry_t'(rd_vec);

    tel_async_fifo #(.W(ENTRY_W), .AW(FIFO_AW)) fifo_i (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_din   (wr_entry),
        .overflow (wr_overflow),
        .rd_clk   (ser_clk),
        .rd_rst_n (ser_rst_n),
        .rd_en    (fifo_pop),
        .rd_dout  (rd_vec),
        .empty    (fifo_empty)
    );

    tel_framer framer_i (
        .clk        (ser_clk),
        .rst_n      (ser_rst_n),
        .fifo_empty (fifo_empty),
        .fifo_head  (rd_entry),
        .fifo_pop   (fifo_pop),
        .ser_out    (ser_out)
    );

    always_ff @(posedge ser_clk or negedge ser_rst_n) begin
        if (!ser_rst_n) div_cnt <= '0;
        else            div_cnt <= div_cnt + 1'b1;
    end
    assign ser_clk_div = div_cnt[DIV_LOG2-1];

    AST_DIV_HIGH_AFTER_RISE: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
        $rose(ser_clk_div) |=> ser_clk_div); // R10
endmodule

// File: tb/telegram_tx_tb_top.sv
`timescale 1ns/1ps
module telegram_tx_tb_top;
    localparam int SER_PERIOD_NS = 10;
    localparam int WR_PERIOD_NS  = 14;

    logic ser_clk = 1'b0, wr_clk = 1'b0;
    logic ser_rst_n = 1'b0, wr_rst_n = 1'b0;
    logic wr_en = 1'b0, wr_is_data = 1'b0;
    logic [7:0] wr_type = '0;
    logic [31:0] wr_data = '0;
    logic wr_overflow, ser_out, ser_clk_div;

    always #(SER_PERIOD_NS/2) ser_clk = ~ser_clk;
    always #(WR_PERIOD_NS/2)  wr_clk  = ~wr_clk;

    telegram_tx dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_is_data(wr_is_data),
        .wr_type(wr_type), .wr_data(wr_data), .wr_overflow(wr_overflow),
        .ser_clk(ser_clk), .ser_rst_n(ser_rst_n), .ser_out(ser_out), .ser_clk_div(ser_clk_div)
    );

    typedef struct {
        bit        is_data;
        bit [7:0]  kind;
        bit [31:0] data;
        bit        must;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0, n_fail = 0, must_pending = 0, opt_rx = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // CRC-8 by polynomial division of the augmented message
    function automatic bit [7:0] ref_crc(input bit [39:0] msg, input int nbits);
        bit [8:0] rem = '0;
        for (int i = nbits - 1; i >= 0; i--) begin
            rem = {rem[7:0], msg[i]};
            if (rem[8]) rem = rem ^ 9'h107;
        end
        for (int i = 0; i < 8; i++) begin
            rem = {rem[7:0], 1'b0};
            if (rem[8]) rem = rem ^ 9'h107;
        end
        return rem[7:0];
    endfunction

    task automatic get_bits(input int n, output logic [63:0] v);
        v = '0;
        repeat (n) begin
            @(negedge ser_clk);
            v = {v[62:0], ser_out};
        end
    endtask

    task automatic send(input bit d, input bit [7:0] k, input bit [31:0] v, input bit m);
        exp_t e;
        @(negedge wr_clk);
        wr_en = 1'b1; wr_is_data = d; wr_type = k; wr_data = v;
        e.is_data = d; e.kind = k; e.data = v; e.must = m;
        exp_q.push_back(e);
        if (m) must_pending++;
    endtask

    task automatic end_writes();
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // line parser
    initial begin : parser
        logic [63:0] b0, b1, w, c;
        exp_t e;
        bit first = 1'b1;
        @(posedge ser_rst_n);
        forever begin
            get_bits(8, b0);
            if (!first && b0[7:0] == 8'h2C) begin
                get_bits(8, b1);
                while (exp_q.size() > 0 && exp_q[0].kind != b1[7:0] && !exp_q[0].must)
                    void'(exp_q.pop_front());
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "packet without pending write", b1[7:0], 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.kind == b1[7:0], "R8", "type byte order", b1[7:0], e.kind);
                    if (e.must) must_pending--; else opt_rx++;
                    if (e.is_data) begin
                        get_bits(32, w);
                        check(w[31:0] == e.data, "R4", "data word", w[31:0], e.data);
                        get_bits(8, c);
                        check(c[7:0] == ref_crc({e.kind, e.data}, 40), "R6", "data crc",
                              c[7:0], ref_crc({e.kind, e.data}, 40));
                    end else begin
                        get_bits(8, c);
                        check(c[7:0] == ref_crc({32'h0, e.kind}, 8), "R6", "event crc",
                              c[7:0], ref_crc({32'h0, e.kind}, 8));
                    end
                    get_bits(16, w);
                    // a wrong length (format) breaks this word
                    check(w[15:0] == 16'h5885, e.is_data ? "R7 R4 R5" : "R7 R3 R5",
                          "idle word after packet", w[15:0], 16'h5885);
                end
            end else begin
                get_bits(8, b1);
                check({b0[7:0], b1[7:0]} == 16'h5885, first ? "R1 (first word)" : "R1 R7",
                      "idle word", {b0[7:0], b1[7:0]}, 16'h5885);
                first = 1'b0;
            end
        end
    end

    // divided clock: low 2, high 2 from reset (R10)
    initial begin : div_check
        @(posedge ser_rst_n);
        for (int n = 0; n < 32; n++) begin
            @(negedge ser_clk);
            check(ser_clk_div == ((n % 4) >= 2), "R10", "divided clock", ser_clk_div, (n % 4) >= 2);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge ser_clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog: actual=timeout expected=all packets sent");
        finish_run();
    end

    initial begin : main
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge ser_clk);
        #1;
        ser_rst_n = 1'b1;
        wr_rst_n  = 1'b1;
        @(negedge wr_clk);
        check(wr_overflow == 1'b0, "R9", "overflow after reset", wr_overflow, 0);

        // directed corner cases: extreme values, both formats
        send(1'b0, 8'h00, 32'h0, 1'b1);
        send(1'b1, 8'hFF, 32'hFFFF_FFFF, 1'b1);
        send(1'b1, 8'h2C, 32'h0000_0000, 1'b1);
        send(1'b0, 8'h58, 32'hDEAD_BEEF, 1'b1);
        end_writes();
        while (must_pending > 0) @(posedge ser_clk);

        // random groups, never more than 8 outstanding
        for (int g = 0; g < 12; g++) begin
            int n;
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < n; i++)
                send(1'($urandom), 8'($urandom), $urandom, 1'b1);
            end_writes();
            repeat (int'($urandom % 40)) @(posedge ser_clk);
            while (must_pending > 0) @(posedge ser_clk);
        end

        @(negedge wr_clk);
        check(wr_overflow == 1'b0, "R9", "no overflow before burst", wr_overflow, 0);

        // burst of 24: first 16 fit, later ones may be dropped
        for (int i = 0; i < 24; i++)
            send(1'b1, 8'hA0 + 8'(i), $urandom, i < 16);
        end_writes();
        while (must_pending > 0) @(posedge ser_clk);
        repeat (400) @(posedge ser_clk);
        @(negedge wr_clk);
        check(wr_overflow == 1'b1, "R9", "overflow after burst", wr_overflow, 1);
        check(opt_rx < 8, "R9", "writes beyond capacity dropped", opt_rx, 7);
        check(must_pending == 0, "R2 R8", "all accepted packets received", must_pending, 0);
        repeat (20) @(posedge wr_clk);
        @(negedge wr_clk);
        check(wr_overflow == 1'b1, "R9", "overflow stays set", wr_overflow, 1);
        finish_run();
    end
endmodule